// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a hardware watchdog that sits on a small 16-bit register port. Software writes a timeout, counted in coarse 128 ms ticks, and then sets a run bit in a control register. From then on the block counts down once per tick. Software keeps the system alive by rewriting the timeout register, which reloads the count. If software stops doing this, the block first raises a non-maskable interrupt while a fixed number of ticks still remain. When the count runs out, it drives a system reset pulse that removes power.

A prescaler turns the input clock into a one-cycle tick. Its divide ratio is a parameter, so a test build can run many ticks in a few clock cycles. Timeout values written by software are clamped into the supported range. Reading the timeout register returns the count that remains, and reading the control register returns the last value written. After a reset pulse the block is disabled again and waits to be re-armed.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register reads 0, the timeout register reads `DEF_TICKS` (234, which is 30 s), and both the interrupt and the reset output are low.
- R2: A timeout write is clamped into `[MIN_TICKS, MAX_TICKS]` (234..4687 ticks by default, which is 30 s to 600 s). While the block is idle, a read at timeout offset `TMR_OFS` (0x70) returns the clamped value.
- R3: A write to control offset `CTL_OFS` (0x72) stores the low `CTL_W` bits, and they read back as written. Bit 0 is the run enable. Writing a value with bit 0 set (for example 0x85) while the block is idle starts the countdown from the stored timeout. A value with bit 0 clear starts nothing.
- R4: While the block runs, the count read at `TMR_OFS` drops by one every `TICK_DIV` clock cycles. The first drop comes `TICK_DIV` cycles after the edge that took the arming write. While the block is idle, the count does not move.
- R5: A timeout write while the block runs is a kick. The count takes the new clamped value, and the prescaler restarts, so the next drop comes a full `TICK_DIV` cycles after the kick.
- R6: The interrupt output is high exactly when the block runs and the count is at or below `PRE_TICKS` (70 by default, about 9 s). If the loaded count is already that low, the interrupt rises on the edge that arms the block. Only a kick to a higher value, a disable, or an expiry lowers it.
- R7: When a tick arrives with a count of 1, the reset output goes high for `RST_CYC` cycles, starting on that edge. On the same edge the control register clears to 0, the count returns to the stored timeout, and the interrupt drops.
- R8: Writing the control value with bit 0 cleared (read-modify-write with mask 0xFE) stops the countdown. The other control bits keep their values, the count returns to the stored timeout, the interrupt drops, and no reset follows.
- R9: A kick that arrives in the same cycle as the expiring tick wins. No reset pulse is issued, and the count takes the kick value.
- R10: While the reset output is high, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`: the remaining count or the control value; 0 at any other offset |
| nmi_o | output | 1 | Early-warning non-maskable interrupt, a level |
| sys_rst_o | output | 1 | System reset / power-removal pulse |

## Verification
The bench goes after the tick phase. A design that does not restart its prescaler on a kick would drop the count one or more cycles early, and the read three cycles after the kick would show that. It also aims a kick at the exact expiring tick. A design that gives expiry priority would pulse the reset even though software was alive. The interrupt is checked on the cycle before and the cycle of the threshold crossing, and also when the block is armed with a count that is already below the threshold. These checks catch an off-by-one compare and an interrupt that waits for the next tick. Finally, the bench writes the control register during the reset pulse and after a stop. A design that re-arms during the pulse, or that loses the upper control bits on a stop, reads back the wrong value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Which register the current bus offset selects.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_TMR  = 2'd1,
      SEL_CTL  = 2'd2
   } wdt_sel_e;

   // One-cycle control events from the register file to the counter.
   typedef struct packed {
      logic kick;   // accepted timeout write
      logic arm;    // run bit set while idle
      logic stop;   // run bit cleared while running
   } wdt_evt_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int unsigned TICK_DIV = 6400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV == 1) begin : g_pass
      logic unused_restart;
      assign unused_restart = restart_i;
      assign tick_o = run_i;
   end else begin : g_div
      logic [PW-1:0] ph_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ph_q <= '0;
         else if (!run_i || restart_i)        ph_q <= '0;
         else if (ph_q == PW'(TICK_DIV - 1))  ph_q <= '0;
         else                                 ph_q <= ph_q + 1'b1;
      end

      assign tick_o = run_i && !restart_i && (ph_q == PW'(TICK_DIV - 1));

      // Ticks are single cycles separated by at least one idle cycle.
      assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned CTL_W     = 8,
   parameter int unsigned TMR_OFS   = 'h70,
   parameter int unsigned CTL_OFS   = 'h72,
   parameter int unsigned MIN_TICKS = 234,
   parameter int unsigned MAX_TICKS = 4687,
   parameter int unsigned DEF_TICKS = 234
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              busy_i,
   input  logic              expire_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              run_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic [CNT_W-1:0]  load_val_o,
   output wdt_evt_t          evt_o
);
   logic [CTL_W-1:0]  ctl_q;
   logic [CNT_W-1:0]  reload_q;
   logic [DATA_W-1:0] ctl_rd;
   wdt_sel_e          sel;
   logic              wr_ok;

   always_comb begin
      sel = SEL_NONE;
      if (addr_i == ADDR_W'(TMR_OFS))      sel = SEL_TMR;
      else if (addr_i == ADDR_W'(CTL_OFS)) sel = SEL_CTL;
   end

   assign wr_ok = wr_i && !busy_i;

   // Clamp the requested timeout into the supported window.
   always_comb begin
      if (wdata_i > DATA_W'(MAX_TICKS))      load_val_o = CNT_W'(MAX_TICKS);
      else if (wdata_i < DATA_W'(MIN_TICKS)) load_val_o = CNT_W'(MIN_TICKS);
      else                                   load_val_o = wdata_i[CNT_W-1:0];
   end

   assign evt_o.kick = wr_ok && (sel == SEL_TMR);
   assign evt_o.arm  = wr_ok && (sel == SEL_CTL) &&  wdata_i[0] && !ctl_q[0];
   assign evt_o.stop = wr_ok && (sel == SEL_CTL) && !wdata_i[0] &&  ctl_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         reload_q <= CNT_W'(DEF_TICKS);
      end else begin
         if (expire_i)                        ctl_q <= '0;
         else if (wr_ok && sel == SEL_CTL)    ctl_q <= wdata_i[CTL_W-1:0];
         if (evt_o.kick)                      reload_q <= load_val_o;
      end
   end

   if (CTL_W == DATA_W) begin : g_ctl_full
      assign ctl_rd = ctl_q;
   end else begin : g_ctl_ext
      assign ctl_rd = {{(DATA_W - CTL_W){1'b0}}, ctl_q};
   end

   always_comb begin
      unique case (sel)
         SEL_TMR: rdata_o = DATA_W'(cnt_i);
         SEL_CTL: rdata_o = ctl_rd;
         default: rdata_o = '0;
      endcase
   end

   assign run_o    = ctl_q[0];
   assign reload_o = reload_q;

   // Stored timeout never leaves the supported window.
   assert_reload_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.kick |=> (reload_q >= CNT_W'(MIN_TICKS)) && (reload_q <= CNT_W'(MAX_TICKS)));

   // Registers are frozen while the reset pulse is out.
   assert_frozen_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(ctl_q) && $stable(reload_q));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DEF_TICKS = 234,
   parameter int unsigned PRE_TICKS = 70,
   parameter int unsigned RST_CYC   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  wdt_evt_t         evt_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o,
   output logic             nmi_o,
   output logic             busy_o
);
   localparam int unsigned RW = $clog2(RST_CYC + 1);

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [RW-1:0]    rcnt_q;
   logic             nmi_q, run_nx;

   // A kick or a stop in the expiring cycle takes priority over the reset.
   assign expire_o = tick_i && run_i && (cnt_q <= CNT_W'(1)) && !evt_i.kick && !evt_i.stop;
   assign run_nx   = evt_i.arm || (run_i && !evt_i.stop && !expire_o);

   always_comb begin
      cnt_nx = cnt_q;
      if (evt_i.kick)                     cnt_nx = load_val_i;
      else if (evt_i.stop || expire_o)    cnt_nx = reload_i;
      else if (tick_i && run_i)           cnt_nx = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(DEF_TICKS);
         nmi_q  <= 1'b0;
         rcnt_q <= '0;
      end else begin
         cnt_q <= cnt_nx;
         nmi_q <= run_nx && (cnt_nx <= CNT_W'(PRE_TICKS));
         if (expire_o)             rcnt_q <= RW'(RST_CYC);
         else if (rcnt_q != '0)    rcnt_q <= rcnt_q - 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign nmi_o  = nmi_q;
   assign busy_o = (rcnt_q != '0);

   // Interrupt only while armed.
   assert_nmi_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> run_i);

   // Free-running countdown moves by at most one per cycle.
   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && !$past(evt_i.kick)) |->
         (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

   // The reset pulse leaves the block disarmed.
   assert_pulse_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !run_i && !nmi_o);

   // A kick is never followed by the start of a reset pulse.
   assert_kick_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.kick |=> !$rose(busy_o));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned CTL_W     = 8,
   parameter int unsigned TMR_OFS   = 'h70,
   parameter int unsigned CTL_OFS   = 'h72,
   parameter int unsigned TICK_DIV  = 6400000,
   parameter int unsigned MIN_TICKS = 234,
   parameter int unsigned MAX_TICKS = 4687,
   parameter int unsigned DEF_TICKS = 234,
   parameter int unsigned PRE_TICKS = 70,
   parameter int unsigned RST_CYC   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              nmi_o,
   output logic              sys_rst_o
);
   if (CNT_W > DATA_W || CTL_W > DATA_W || CTL_W < 1) begin : g_bad_width
      $error("wdt_guard: counter and control widths must fit the data port");
   end
   if (MIN_TICKS < 1 || MIN_TICKS > DEF_TICKS || DEF_TICKS > MAX_TICKS) begin : g_bad_window
      $error("wdt_guard: need 1 <= MIN_TICKS <= DEF_TICKS <= MAX_TICKS");
   end
   if (MAX_TICKS >= (64'd1 << CNT_W) || PRE_TICKS >= (64'd1 << CNT_W)) begin : g_bad_range
      $error("wdt_guard: tick limits exceed the counter width");
   end
   if (TICK_DIV < 1 || RST_CYC < 1 || TMR_OFS == CTL_OFS) begin : g_bad_misc
      $error("wdt_guard: invalid divider, pulse length or register offsets");
   end

   logic             run, tick, expire, busy;
   logic [CNT_W-1:0] cnt, reload, load_val;
   wdt_evt_t         evt;

   wdt_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CTL_W(CTL_W),
      .TMR_OFS(TMR_OFS), .CTL_OFS(CTL_OFS),
      .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS), .DEF_TICKS(DEF_TICKS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
      .busy_i(busy), .expire_i(expire), .cnt_i(cnt),
      .run_o(run), .reload_o(reload), .load_val_o(load_val), .evt_o(evt)
   );

   wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .restart_i(evt.kick || evt.arm), .tick_o(tick)
   );

   wdt_countdown #(
      .CNT_W(CNT_W), .DEF_TICKS(DEF_TICKS), .PRE_TICKS(PRE_TICKS), .RST_CYC(RST_CYC)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
      .reload_i(reload), .load_val_i(load_val), .evt_i(evt),
      .cnt_o(cnt), .expire_o(expire), .nmi_o(nmi_o), .busy_o(busy)
   );

   assign sys_rst_o = busy;
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_TMR = 8'h70;
   localparam logic [7:0] A_CTL = 8'h72;
   localparam int K_RD = 0, K_NMI = 1, K_RST = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        nmi_o, sys_rst_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t q[$];
   item_t it;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_guard #(
      .TICK_DIV(4), .MIN_TICKS(2), .MAX_TICKS(4687), .DEF_TICKS(234),
      .PRE_TICKS(5), .RST_CYC(3)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
   );

   // Monitor: compare every queued expectation at the falling edge.
   always @(negedge clk) begin
      while (q.size() != 0) begin
         logic [15:0] act;
         it = q.pop_front();
         case (it.kind)
            K_RD:    act = bus_rdata;
            K_NMI:   act = {15'd0, nmi_o};
            default: act = {15'd0, sys_rst_o};
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s kind=%0d actual=%0h expected=%0h at %0t",
                     it.tag, it.kind, act, it.exp, $time);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [15:0] e, input string tag);
      item_t x;
      bus_addr = a;
      x.kind = K_RD; x.exp = e; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic exp_nmi(input logic e, input string tag);
      item_t x;
      x.kind = K_NMI; x.exp = {15'd0, e}; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic exp_rst(input logic e, input string tag);
      item_t x;
      x.kind = K_RST; x.exp = {15'd0, e}; x.tag = tag;
      q.push_back(x);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog (all requirements) actual=hung expected=completed");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_CTL; bus_wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      exp_rd(A_CTL, 16'h0000, "R1"); exp_nmi(1'b0, "R1"); exp_rst(1'b0, "R1");
      step();
      exp_rd(A_TMR, 16'd234, "R1");
      step();

      // R2: clamping of the timeout
      wr(A_TMR, 16'd0);      exp_rd(A_TMR, 16'd2, "R2");
      wr(A_TMR, 16'hFFFF);   exp_rd(A_TMR, 16'd4687, "R2");
      wr(A_TMR, 16'd100);    exp_rd(A_TMR, 16'd100, "R2");

      // R3: control store without run bit does not count
      wr(A_CTL, 16'h0084);   exp_rd(A_CTL, 16'h0084, "R3");
      idle(10);              exp_rd(A_TMR, 16'd100, "R4");

      // R3/R4: arm and count
      wr(A_TMR, 16'd10);
      wr(A_CTL, 16'h0085);   exp_rd(A_CTL, 16'h0085, "R3");
      idle(3);               exp_rd(A_TMR, 16'd10, "R4");
      idle(1);               exp_rd(A_TMR, 16'd9, "R4"); exp_nmi(1'b0, "R6");
      idle(4);               exp_rd(A_TMR, 16'd8, "R4");

      // R5: kick restarts the tick phase
      wr(A_TMR, 16'd8);
      idle(3);               exp_rd(A_TMR, 16'd8, "R5");
      idle(1);               exp_rd(A_TMR, 16'd7, "R5");
      // R6: threshold crossing
      idle(7);               exp_rd(A_TMR, 16'd6, "R6"); exp_nmi(1'b0, "R6");
      idle(1);               exp_rd(A_TMR, 16'd5, "R6"); exp_nmi(1'b1, "R6");
      wr(A_TMR, 16'd20);     exp_nmi(1'b0, "R5");

      // R7/R10: expiry and ignored write during the pulse
      wr(A_TMR, 16'd3);      exp_nmi(1'b1, "R6");
      idle(11);              exp_rst(1'b0, "R7"); exp_rd(A_TMR, 16'd1, "R7");
      idle(1);               exp_rst(1'b1, "R7"); exp_nmi(1'b0, "R7");
                             exp_rd(A_CTL, 16'h0000, "R7");
      wr(A_CTL, 16'h0085);   exp_rst(1'b1, "R7"); exp_rd(A_CTL, 16'h0000, "R10");
      step();                exp_rst(1'b0, "R7"); exp_rd(A_TMR, 16'd3, "R7");
      idle(10);              exp_rd(A_TMR, 16'd3, "R10"); exp_nmi(1'b0, "R10");

      // R6 immediate on arm, then R8 stop via read-modify-write
      wr(A_TMR, 16'd4);      exp_nmi(1'b0, "R6");
      wr(A_CTL, 16'h0085);   exp_nmi(1'b1, "R6");
      wr(A_CTL, 16'h0085 & 16'hFFFE);
                             exp_nmi(1'b0, "R8"); exp_rd(A_CTL, 16'h0084, "R8");
      step();                exp_rd(A_TMR, 16'd4, "R8");
      idle(20);              exp_rd(A_TMR, 16'd4, "R8"); exp_rst(1'b0, "R8");

      // R9: kick on the expiring tick
      wr(A_TMR, 16'd2);
      wr(A_CTL, 16'h0085);
      idle(6);
      wr(A_TMR, 16'd2);      exp_rst(1'b0, "R9"); exp_rd(A_TMR, 16'd2, "R9");
      step();                exp_rst(1'b0, "R9");
      idle(4);               exp_rst(1'b0, "R9"); exp_rd(A_TMR, 16'd1, "R9");
      wr(A_CTL, 16'h0084);   exp_rst(1'b0, "R9");
      idle(12);              exp_rst(1'b0, "R8");

      step(); step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule